// File: doc/BRIEF.md
# Four-Bit Sliced Arithmetic Logic Unit

This block is a four-bit arithmetic logic unit built from four identical one-bit slices. Each slice holds three pieces of logic: a full adder, a switch that can invert its b operand, and a four-way selector that picks the slice's result bit. The slices are chained through their carries. The least significant slice takes the external carry input, and each slice's carry-out becomes the next slice's carry-in.

A two-bit operation code selects one of four results. Code 00 is bitwise AND, code 01 is bitwise OR, code 10 is the adder sum, and code 11 is set-if-less-than. Subtraction is not a separate code. The user asks for it with the adder code, with the invert-b input set to 1 and the carry input set to 1, so that the chain computes a + ~b + 1.

For set-if-less-than, the sum bit of the most significant slice is sent back to the less input of the least significant slice. The less inputs of all other slices are tied to 0. The sign is taken raw, with no correction for overflow, so a subtraction that overflows gives the uncorrected answer.

The block is purely combinational. It has no clock, no reset and no handshake, so no valid/ready back-pressure applies. The result follows the inputs.

Top module: `slice_alu`

## Requirements
- R1: With op_i = 00 and b_invert_i = 0, result_o equals a_i AND b_i, bit by bit.
- R2: With op_i = 01 and b_invert_i = 0, result_o equals a_i OR b_i, bit by bit.
- R3: With op_i = 10 and b_invert_i = 0, result_o equals (a_i + b_i + carry_in_i) mod 16.
- R4: With op_i = 10, b_invert_i = 1 and carry_in_i = 1, result_o equals (a_i - b_i) mod 16.
- R5: With b_invert_i = 1, the logic codes use the inverted operand: op_i = 00 gives a_i AND NOT b_i, and op_i = 01 gives a_i OR NOT b_i.
- R6: With op_i = 11, result_o bits 3 down to 1 are 0 for every other input.
- R7: With op_i = 11, result_o bit 0 equals bit 3 of (a_i + b' + carry_in_i) mod 16, where b' is b_i, or NOT b_i when b_invert_i = 1. For signed less-than (b_invert_i = 1, carry_in_i = 1), an overflowing subtraction gives the raw bit, for example a = 0111 and b = 1000 give 0001.
- R8: A carry ripples through all four slices, for example 1111 + 0000 with carry_in_i = 1 gives 0000.
- R9: With op_i = 10, b_invert_i = 1 and carry_in_i = 0, result_o equals (a_i + NOT b_i) mod 16, which is a_i - b_i - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| b_invert_i | input | 1 | Inverts b in every slice when 1 |
| carry_in_i | input | 1 | Carry into the least significant slice |
| op_i | input | 2 | Result select: 00 AND, 01 OR, 10 sum, 11 less |
| result_o | output | 4 | Selected result |

## Verification
The hardest case to reach from the ports is set-if-less-than when the subtraction overflows. In that case the raw sign bit that is fed back disagrees with the true signed order, and only a few operand pairs produce it. The stimulus reaches it in two ways. A directed vector uses 0111 against 1000. In addition, every one of the 256 operand pairs is swept under all sixteen combinations of operation, invert and carry, which covers every overflow pair and every carry chain of full length.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_SUM  = 2'b10,
    OP_LESS = 2'b11
  } alu_op_e;
endpackage

// File: rtl/alu_mux2.sv
module alu_mux2 (
  input  logic in0_i,
  input  logic in1_i,
  input  logic sel_i,
  output logic out_o
);
  // sum of products from the two-input select map
  assign out_o = (~sel_i & in0_i) | (sel_i & in1_i);
endmodule

// File: rtl/alu_mux4.sv
module alu_mux4 (
  input  logic [3:0] in_i,
  input  logic [1:0] sel_i,
  output logic       out_o
);
  logic lo_pair, hi_pair;

  alu_mux2 u_lo  (.in0_i(in_i[0]), .in1_i(in_i[1]), .sel_i(sel_i[0]), .out_o(lo_pair));
  alu_mux2 u_hi  (.in0_i(in_i[2]), .in1_i(in_i[3]), .sel_i(sel_i[0]), .out_o(hi_pair));
  alu_mux2 u_top (.in0_i(lo_pair), .in1_i(hi_pair), .sel_i(sel_i[1]), .out_o(out_o));
endmodule

// File: rtl/alu_full_add.sv
module alu_full_add (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i ^ c_i;
  assign c_o = (x_i & c_i) | (y_i & c_i) | (x_i & y_i);
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    b_inv_i,
  input  logic    c_i,
  input  logic    less_i,
  input  alu_op_e op_i,
  output logic    res_o,
  output logic    sum_o,
  output logic    c_o
);
  logic b_eff;
  logic [3:0] choices;

  assign b_eff = b_i ^ b_inv_i;

  alu_full_add u_add (.x_i(a_i), .y_i(b_eff), .c_i(c_i), .s_o(sum_o), .c_o(c_o));

  assign choices = {less_i, sum_o, a_i | b_eff, a_i & b_eff};

  alu_mux4 u_sel (.in_i(choices), .sel_i(op_i), .out_o(res_o));

  // selector output against operand values
  always_comb begin
    if (op_i == OP_AND && !a_i) p_and_mask_r1: assert (res_o == 1'b0);
    if (op_i == OP_OR && a_i)   p_or_dom_r2:   assert (res_o == 1'b1);
  end
endmodule

// File: rtl/slice_alu.sv
module slice_alu #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             b_invert_i,
  input  logic             carry_in_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] result_o
);
  import alu_pkg::*;

  localparam int MSB = WIDTH - 1;

  alu_op_e          op;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] less;

  assign op       = alu_op_e'(op_i);
  assign carry[0] = carry_in_i;

  // sign of the top slice feeds bit 0; others see zero
  always_comb begin
    less    = '0;
    less[0] = sum[MSB];
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_slice
    alu_bit_slice u_slice (
      .a_i    (a_i[g]),
      .b_i    (b_i[g]),
      .b_inv_i(b_invert_i),
      .c_i    (carry[g]),
      .less_i (less[g]),
      .op_i   (op),
      .res_o  (result_o[g]),
      .sum_o  (sum[g]),
      .c_o    (carry[g+1])
    );
  end

  // ripple chain compared with whole-word arithmetic
  logic [WIDTH-1:0] b_word;
  logic [WIDTH:0]   arith;
  always_comb begin
    b_word = b_invert_i ? ~b_i : b_i;
    arith  = {1'b0, a_i} + {1'b0, b_word} + {{WIDTH{1'b0}}, carry_in_i};
    p_ripple_r8: assert ({carry[WIDTH], sum} == arith);
    if (op == OP_SUM)  p_sum_out_r3:    assert (result_o == arith[WIDTH-1:0]);
    if (op == OP_LESS) p_upper_zero_r6: assert (result_o[WIDTH-1:1] == '0);
    if (op == OP_LESS) p_less_route_r7: assert (result_o[0] == arith[MSB]);
  end
endmodule

// File: tb/test_slice_alu.sv
module test_slice_alu;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [3:0] a, b, res;
  logic       inv, cin;
  logic [1:0] op;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  slice_alu i_slice_alu (
    .a_i(a), .b_i(b), .b_invert_i(inv), .carry_in_i(cin), .op_i(op), .result_o(res)
  );

  typedef struct packed {
    logic [3:0] a;
    logic [3:0] b;
    logic       inv;
    logic       cin;
    logic [1:0] op;
    logic [3:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{4'hC, 4'hA, 1'b0, 1'b0, 2'b00, 4'h8},
    '{4'hC, 4'hA, 1'b0, 1'b0, 2'b01, 4'hE},
    '{4'h7, 4'h5, 1'b0, 1'b0, 2'b10, 4'hC},
    '{4'hF, 4'h0, 1'b0, 1'b1, 2'b10, 4'h0},
    '{4'h3, 4'h5, 1'b1, 1'b1, 2'b10, 4'hE},
    '{4'h5, 4'h3, 1'b1, 1'b1, 2'b10, 4'h2},
    '{4'h2, 4'h6, 1'b1, 1'b1, 2'b11, 4'h1},
    '{4'h6, 4'h2, 1'b1, 1'b1, 2'b11, 4'h0},
    '{4'h7, 4'h8, 1'b1, 1'b1, 2'b11, 4'h1},
    '{4'hF, 4'h5, 1'b1, 1'b0, 2'b00, 4'hA},
    '{4'h0, 4'hF, 1'b1, 1'b0, 2'b01, 4'h0},
    '{4'h5, 4'h3, 1'b1, 1'b0, 2'b10, 4'h1},
    '{4'hF, 4'hF, 1'b0, 1'b0, 2'b11, 4'h1}
  };
  localparam string VTAG [NV] = '{"R1", "R2", "R3", "R8", "R4", "R4", "R7",
                                  "R7", "R7", "R5", "R5", "R9", "R6"};

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h inv=%b cin=%b op=%b got=%h exp=%h",
               tag, a, b, inv, cin, op, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] ta, input logic [3:0] tb, input logic ti,
                       input logic tc, input logic [1:0] to);
    @(posedge clk);
    a = ta; b = tb; inv = ti; cin = tc; op = to;
    @(negedge clk);
  endtask

  function automatic logic [3:0] model(input logic [3:0] ma, input logic [3:0] mb,
                                       input logic mi, input logic mc, input logic [1:0] mo);
    int bp, s;
    bp = mi ? (15 - int'(mb)) : int'(mb);
    s  = (int'(ma) + bp + int'(mc)) % 16;
    case (mo)
      2'b00: return ma & 4'(bp);
      2'b01: return ma | 4'(bp);
      2'b10: return 4'(s);
      default: return (s >= 8) ? 4'h1 : 4'h0;
    endcase
  endfunction

  initial begin
    a = '0; b = '0; inv = 1'b0; cin = 1'b0; op = 2'b00;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle", res, 4'h0);

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v].a, VEC[v].b, VEC[v].inv, VEC[v].cin, VEC[v].op);
      check(VTAG[v], res, VEC[v].exp);
    end

    // R6 with every operand pair is covered by the sweep below
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 256; p++) begin
        logic [1:0] so;
        logic si, sc;
        string tg;
        so = m[3:2]; si = m[1]; sc = m[0];
        case (so)
          2'b00: tg = si ? "R5" : "R1";
          2'b01: tg = si ? "R5" : "R2";
          2'b10: tg = (si && sc) ? "R4" : (si ? "R9" : "R3");
          default: tg = "R6/R7";
        endcase
        apply(p[7:4], p[3:0], si, sc, so);
        check(tg, res, model(p[7:4], p[3:0], si, sc, so));
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule